// File: doc/BRIEF.md
# Reciprocal-Multiply Sample Scaler

This block divides a continuous stream of unsigned samples by a run-time variable without any divider hardware. Each sample is multiplied by a stored reciprocal coefficient in Q1.15 fixed point, where 1.0 is encoded as 0x8000. The product is then brought back to sample scale by dropping its 15 lowest bits. One sample is accepted every clock, and each result appears a fixed two cycles later.

The coefficient comes from one of two sources, chosen on each load. In direct mode the host already knows the reciprocal and writes the Q1.15 coefficient itself. In lookup mode the host writes the divisor. The block finds the position of the divisor's leading one and uses the six bits just below it to address a 64-entry table of approximate reciprocals. It then applies an extra right shift equal to that leading-one position. A load changes the coefficient used by later samples only. Samples already in the pipeline keep the coefficient they started with.

Top module: `recip_scaler`

## Requirements
- R1: In direct mode (`ld_lut`=0) with a coefficient no larger than 0x8000, `out_data` equals floor(`in_data` × coefficient / 2^15) exactly.
- R2: A direct coefficient of 0x3000 scales a sample by 0.375, so a sample of 8000 yields 3000.
- R3: `out_valid` is high on the second clock edge after the edge that captured a sample with `in_valid` high. It is low two edges after any edge that saw `in_valid` low.
- R4: Samples presented on consecutive cycles produce results on consecutive cycles, in the same order.
- R5: Take a load captured at edge E. Samples captured at edges E and E+1 use the previous coefficient. Samples captured from edge E+2 onward use the new one.
- R6: In lookup mode (`ld_lut`=1) with a nonzero divisor D, the output q satisfies |q×D − s| ≤ s/100 + 2×D for sample s.
- R7: In lookup mode with a divisor of zero, every output is 0xFFFF.
- R8: If a direct coefficient above 0x8000 makes the rescaled result exceed 0xFFFF, the output is 0xFFFF rather than a wrapped value.
- R9: After reset, `out_valid` is low and the coefficient is 1.0 (0x8000, direct mode), so a sample passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 | Unsigned input sample |
| ld_valid | input | 1 | Load strobe for `ld_value` |
| ld_lut | input | 1 | 1: `ld_value` is a divisor (lookup mode); 0: `ld_value` is a Q1.15 coefficient |
| ld_value | input | 16 | Divisor or coefficient to load |
| out_valid | output | 1 | Result strobe |
| out_data | output | 16 | Scaled, saturated result |

## Verification
A coefficient load and a sample can arrive in the same cycle. The bench does this on purpose: it asserts a load of coefficient 0x4000 in the same cycle as the first of four back-to-back samples. The samples captured at the load edge and at the next edge must still come out unscaled. The later two must come out halved, which shows both the two-cycle take-effect rule and the fact that in-flight samples are isolated from a new load. Lookup results are judged against a tolerance band around the exact quotient, and direct-mode results are judged for exact equality.

// File: rtl/scaler_pkg.sv
package scaler_pkg;

  // Rounded reciprocal of the bucket midpoint 1 + (idx + 0.5) / 2^idx_w,
  // scaled by 2^frac_w.
  function automatic int recip_entry(int idx, int idx_w, int frac_w);
    int num;
    int den;
    num = 1 << (frac_w + idx_w + 2);
    den = (1 << (idx_w + 1)) + 2 * idx + 1;
    return (num / den + 1) / 2;
  endfunction

endpackage

// File: rtl/recip_lut.sv
module recip_lut #(
  parameter int DIV_W  = 16,
  parameter int COEF_W = 16,
  parameter int IDX_W  = 6,
  parameter int FRAC_W = 15,
  localparam int SHIFT_W = $clog2(DIV_W)
) (
  input  logic [DIV_W-1:0]   divisor,
  output logic [COEF_W-1:0]  recip,
  output logic [SHIFT_W-1:0] shift,
  output logic               is_zero
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [COEF_W-1:0] table_q [ENTRIES];
  logic [DIV_W-1:0]  norm;
  logic [IDX_W-1:0]  idx;
  logic [SHIFT_W-1:0] lead;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_tab
      assign table_q[g] = COEF_W'(scaler_pkg::recip_entry(g, IDX_W, FRAC_W));
    end
  endgenerate

  // Position of the highest set bit.
  always_comb begin
    lead = '0;
    for (int b = 0; b < DIV_W; b++) begin
      if (divisor[b]) lead = SHIFT_W'(b);
    end
  end

  assign norm    = divisor << (SHIFT_W'(DIV_W - 1) - lead);
  assign idx     = norm[DIV_W-2 -: IDX_W];
  assign recip   = table_q[idx];
  assign shift   = lead;
  assign is_zero = (divisor == '0);

endmodule

// File: rtl/coef_stage.sv
module coef_stage #(
  parameter int DIV_W  = 16,
  parameter int COEF_W = 16,
  parameter int IDX_W  = 6,
  parameter int FRAC_W = 15,
  localparam int SHIFT_W = $clog2(DIV_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_valid,
  input  logic               ld_lut,
  input  logic [DIV_W-1:0]   ld_value,
  output logic [COEF_W-1:0]  act_coef,
  output logic [SHIFT_W-1:0] act_shift,
  output logic               act_sat
);
  localparam logic [COEF_W-1:0] ONE = COEF_W'(1) << FRAC_W;

  logic               pend_valid;
  logic               pend_lut;
  logic [DIV_W-1:0]   pend_val;

  logic [COEF_W-1:0]  lut_recip;
  logic [SHIFT_W-1:0] lut_shift;
  logic               lut_zero;

  logic [COEF_W-1:0]  coef_d;
  logic [SHIFT_W-1:0] shift_d;
  logic               sat_d;

  recip_lut #(
    .DIV_W (DIV_W),
    .COEF_W(COEF_W),
    .IDX_W (IDX_W),
    .FRAC_W(FRAC_W)
  ) u_lut (
    .divisor(pend_val),
    .recip  (lut_recip),
    .shift  (lut_shift),
    .is_zero(lut_zero)
  );

  // First stage: hold the raw load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_lut   <= 1'b0;
      pend_val   <= '0;
    end else begin
      pend_valid <= ld_valid;
      if (ld_valid) begin
        pend_lut <= ld_lut;
        pend_val <= ld_value;
      end
    end
  end

  // Second stage: pick the coefficient source.
  always_comb begin
    if (pend_lut) begin
      coef_d  = lut_recip;
      shift_d = lut_shift;
      sat_d   = lut_zero;
    end else begin
      coef_d  = COEF_W'(pend_val);
      shift_d = '0;
      sat_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_coef  <= ONE;
      act_shift <= '0;
      act_sat   <= 1'b0;
    end else if (pend_valid) begin
      act_coef  <= coef_d;
      act_shift <= shift_d;
      act_sat   <= sat_d;
    end
  end

  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pend_valid) |-> ($stable(act_coef) && $stable(act_shift) && $stable(act_sat))) // R5
    else $error("coefficient changed without a pending load");

  AST_LUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_valid) && $past(pend_lut) && !act_sat) |-> (act_coef <= ONE && act_coef > (ONE >> 1))) // R6
    else $error("lookup reciprocal outside (0.5, 1.0]");

  AST_HOST_NOSHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_valid) && !$past(pend_lut)) |-> (act_shift == '0 && !act_sat)) // R1
    else $error("direct coefficient carries shift or saturation");

endmodule

// File: rtl/mult_stage.sv
module mult_stage #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 15,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [COEF_W-1:0]  coef,
  input  logic [SHIFT_W-1:0] shift,
  input  logic               sat,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam logic [DATA_W-1:0] MAXV = '1;

  logic               p_valid;
  logic [PROD_W-1:0]  p_prod;
  logic [SHIFT_W-1:0] p_shift;
  logic               p_sat;

  logic [PROD_W-1:0]  prod_d;
  logic [PROD_W-1:0]  scaled;
  logic [DATA_W-1:0]  res_d;

  assign prod_d = PROD_W'(in_data) * PROD_W'(coef);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_valid <= 1'b0;
      p_prod  <= '0;
      p_shift <= '0;
      p_sat   <= 1'b0;
    end else begin
      p_valid <= in_valid;
      if (in_valid) begin
        p_prod  <= prod_d;
        p_shift <= shift;
        p_sat   <= sat;
      end
    end
  end

  always_comb begin
    scaled = (p_prod >> FRAC_W) >> p_shift;
    if (p_sat || (scaled[PROD_W-1:DATA_W] != '0)) res_d = MAXV;
    else                                          res_d = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= p_valid;
      if (p_valid) out_data <= res_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(p_valid) && $past(p_sat)) |-> (out_data == MAXV)) // R7
    else $error("zero divisor did not saturate");

  AST_SAT_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(p_valid) && ($past(p_prod) >> FRAC_W) > PROD_W'(MAXV)) |-> (out_data == MAXV)) // R8
    else $error("wide product wrapped");

endmodule

// File: rtl/recip_scaler.sv
module recip_scaler #(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 16,
  parameter int COEF_W = 16,
  parameter int IDX_W  = 6,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              ld_valid,
  input  logic              ld_lut,
  input  logic [DIV_W-1:0]  ld_value,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int SHIFT_W = $clog2(DIV_W);

  logic [1:0]         rst_sync;
  logic               rst_int_n;
  logic [COEF_W-1:0]  act_coef;
  logic [SHIFT_W-1:0] act_shift;
  logic               act_sat;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  coef_stage #(
    .DIV_W (DIV_W),
    .COEF_W(COEF_W),
    .IDX_W (IDX_W),
    .FRAC_W(FRAC_W)
  ) u_coef (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ld_valid (ld_valid),
    .ld_lut   (ld_lut),
    .ld_value (ld_value),
    .act_coef (act_coef),
    .act_shift(act_shift),
    .act_sat  (act_sat)
  );

  mult_stage #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .FRAC_W (FRAC_W),
    .SHIFT_W(SHIFT_W)
  ) u_mult (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .coef     (act_coef),
    .shift    (act_shift),
    .sat      (act_sat),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |-> ##2 out_valid) // R3
    else $error("out_valid missing two edges after sample");

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |-> ##2 !out_valid) // R3
    else $error("out_valid without a sample");

endmodule

// File: tb/recip_scaler_test.sv
module recip_scaler_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic        ld_valid;
  logic        ld_lut;
  logic [15:0] ld_value;
  logic        out_valid;
  logic [15:0] out_data;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  recip_scaler uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .ld_valid(ld_valid), .ld_lut(ld_lut), .ld_value(ld_value),
    .out_valid(out_valid), .out_data(out_data)
  );

  // {lookup, value, sample}
  localparam int NV = 15;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'h3000, 16'd8000},
    {1'b0, 16'h8000, 16'd12345},
    {1'b0, 16'h4000, 16'd777},
    {1'b0, 16'h0001, 16'd65535},
    {1'b0, 16'h0000, 16'd5000},
    {1'b0, 16'hC000, 16'd1000},
    {1'b0, 16'hC000, 16'd50000},
    {1'b0, 16'hFFFF, 16'd65535},
    {1'b1, 16'h0003, 16'd60000},
    {1'b1, 16'h0001, 16'd4321},
    {1'b1, 16'h00FF, 16'd65535},
    {1'b1, 16'h1234, 16'd65535},
    {1'b1, 16'hFFFF, 16'd65535},
    {1'b1, 16'h0000, 16'd100},
    {1'b1, 16'h0007, 16'd0}
  };

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    ld_valid = 1'b0;
  endtask

  task automatic run_vec(input logic lut, input logic [15:0] val, input logic [15:0] s);
    longint e;
    longint q;
    @(negedge clk);
    ld_valid = 1'b1; ld_lut = lut; ld_value = val; in_valid = 1'b0;
    idle();
    @(negedge clk);
    in_valid = 1'b1; in_data = s;
    idle();
    @(negedge clk);
    q = longint'(out_data);
    check("R3", out_valid === 1'b1, longint'(out_valid), 1);
    if (!lut) begin
      e = (longint'(s) * longint'(val)) >>> 15;
      if (e > 65535) e = 65535;
      if (val == 16'h3000) check("R2", q == e, q, e);
      else if (e == 65535) check("R8", q == e, q, e);
      else                 check("R1", q == e, q, e);
    end else if (val == 16'h0) begin
      check("R7", q == 65535, q, 65535);
    end else begin
      e = longint'(s) / longint'(val);
      q = q * longint'(val) - longint'(s);
      if (q < 0) q = -q;
      check("R6", q <= longint'(s) / 100 + 2 * longint'(val), longint'(out_data), e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    ld_valid = 1'b0; ld_lut = 1'b0; ld_value = '0;
    repeat (3) @(negedge clk);
    check("R9", out_valid === 1'b0, longint'(out_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", out_valid === 1'b0, longint'(out_valid), 0);

    // R9 / R3: unity coefficient after reset, valid timing
    in_valid = 1'b1; in_data = 16'd1234;
    idle();
    check("R3", out_valid === 1'b0, longint'(out_valid), 0);
    @(negedge clk);
    check("R3", out_valid === 1'b1, longint'(out_valid), 1);
    check("R9", out_data == 16'd1234, longint'(out_data), 1234);
    @(negedge clk);
    check("R3", out_valid === 1'b0, longint'(out_valid), 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i][32], VEC[i][31:16], VEC[i][15:0]);

    // R5 / R4: load 1.0, then load 0.5 in the same cycle as a burst of four samples
    @(negedge clk);
    ld_valid = 1'b1; ld_lut = 1'b0; ld_value = 16'h8000; in_valid = 1'b0;
    idle();
    idle();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      ld_valid = (k == 0);
      ld_value = 16'h4000;
      in_valid = (k < 4);
      in_data  = 16'(1000 + 100 * k);
      if (k >= 2) begin
        check("R4", out_valid === 1'b1, longint'(out_valid), 1);
        if (k - 2 < 2)
          check("R5", out_data == 16'(1000 + 100 * (k - 2)), longint'(out_data), 1000 + 100 * (k - 2));
        else
          check("R5", out_data == 16'((1000 + 100 * (k - 2)) / 2), longint'(out_data), (1000 + 100 * (k - 2)) / 2);
      end
    end
    idle();
    idle();
    check("R3", out_valid === 1'b0, longint'(out_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule